// File: doc/BRIEF.md
# Single-Slope Column Converter Digital Backend

This block is the digital half of a bank of per-column single-slope converters. One shared sequencer walks a 10-bit count through one value per clock. It publishes that count on a Gray-coded bus that every column sees, and it drives a 14-bit ramp code to an external DAC. The ramp is companding: the ramp code rises by 1 per count in the lower half of the count range, by 2 in the third quarter and by 4 in the top quarter. Large signals therefore convert with coarser steps, and a full conversion stays at 1024 clocks.

Each column passes its comparator output through a two-stage synchronizer. A keeper latch then records only the first trip of a conversion and writes the Gray code on the bus into one of two storage words. An accepted start swaps the two words. New results therefore land in one word while the other still holds the previous conversion. A registered column-select decoder reads that previous word, turns it into binary and places it on an 11-bit data bus. A column that never trips gets the full-scale code and an overrange flag.

Top module: `scs_adc_backend`

## Requirements
- R1: After reset, `dac_code`, `gray_bus` and `col_data` are all zero and no conversion is running.
- R2: A `conv_start` seen while idle starts a conversion. Counting the clock edge that accepts the start as edge 0, the internal count is k after edge k, for k = 0..1023. `gray_bus` equals k XOR (k >> 1), so exactly one bit changes per step.
- R3: While count k is current, `dac_code` equals k for k < 512, 2k − 512 for 512 ≤ k < 768, and 4k − 2048 for k ≥ 768.
- R4: The clock edge that ends count 1023 finishes the conversion and returns `dac_code` and `gray_bus` to zero.
- R5: Suppose a column's comparator is first sampled high at the clock edge that ends count c, and c + 2 ≤ 1023. That column then stores code c + 2, which accounts for the two synchronizer stages, with its overrange bit clear.
- R6: Only the first trip of a conversion is stored. A comparator that stays high afterwards changes nothing.
- R7: A column that has not tripped by the edge ending count 1023 stores code 1023 with its overrange bit set. A trip that arrives exactly at count 1023 stores 1023 with the overrange bit clear.
- R8: Each accepted start swaps the write word and the read word of every column. `col_data` therefore shows the result of the conversion before the most recently accepted start. Before the second start it shows zeros.
- R9: `col_data` is registered. One clock after `col_sel` = a (a < NCOL), it holds the overrange bit in bit 10 and column a's code, converted back to binary, in bits 9:0.
- R10: One clock after `col_sel` ≥ NCOL, `col_data` is zero.
- R11: A `conv_start` that arrives while a conversion is running is ignored. The count, the ramp and the word selection carry on undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Start request for a conversion, honoured only while idle |
| cmp_in | input | NCOL | Raw comparator outputs, one per column, asynchronous |
| col_sel | input | ADDR_W | Column to read out |
| dac_code | output | 14 | Ramp code for the external DAC |
| gray_bus | output | 10 | Shared Gray-coded count bus |
| col_data | output | 11 | Selected column result: bit 10 overrange, bits 9:0 binary code |

## Verification
Two things can happen in the same clock: comparator trips are written into one word of each column, and `col_data` is read out of the other word. The bench provokes this by sweeping all column addresses in the middle of every conversion, while thresholds set on the live `dac_code` keep tripping columns. It judges each read against the values that a bench model predicted for the conversion before. A second coincidence is a start request that lands in a running conversion. The bench judges it by checking the ramp and Gray values cycle by cycle across that request, and by checking the results of that conversion when they are read out later.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int CODE_W = 10;
  localparam int DAC_W  = 14;
  localparam int OUT_W  = CODE_W + 1;
  localparam int NSEG   = 3;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [DAC_W-1:0]  dac_t;

  typedef struct packed {
    logic  ovr;
    code_t code;
  } entry_t;

  localparam code_t CODE_MAX = {CODE_W{1'b1}};

  // lower edges of segments 1 and 2 of the ramp schedule
  localparam int SEG1_LO = 1 << (CODE_W - 1);
  localparam int SEG2_LO = 3 << (CODE_W - 2);

  function automatic code_t bin2gray(code_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic code_t gray2bin(code_t g);
    code_t b;
    b[CODE_W-1] = g[CODE_W-1];
    for (int i = CODE_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic int unsigned seg_of(code_t c);
    if (int'(c) < SEG1_LO) return 0;
    else if (int'(c) < SEG2_LO) return 1;
    else return 2;
  endfunction

  // ramp increment applied when leaving count c: doubles per segment
  function automatic dac_t step_of(code_t c);
    return dac_t'(1) << seg_of(c);
  endfunction
endpackage

// File: rtl/scs_ramp_seq.sv
module scs_ramp_seq
  import scs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  conv_start,
  output logic  run_q,
  output logic  start_acc,
  output logic  cnt_last,
  output logic  wr_sel,
  output code_t gray,
  output dac_t  dac
);
  code_t count_q;
  dac_t  dac_q;

  assign start_acc = conv_start && !run_q;
  assign cnt_last  = run_q && (count_q == CODE_MAX);
  assign gray      = bin2gray(count_q);
  assign dac       = dac_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      count_q <= '0;
      dac_q   <= '0;
      wr_sel  <= 1'b0;
    end else if (start_acc) begin
      run_q   <= 1'b1;
      count_q <= '0;
      dac_q   <= '0;
      wr_sel  <= ~wr_sel;
    end else if (cnt_last) begin
      run_q   <= 1'b0;
      count_q <= '0;
      dac_q   <= '0;
    end else if (run_q) begin
      count_q <= count_q + code_t'(1);
      dac_q   <= dac_q + step_of(count_q);
    end
  end
endmodule

// File: rtl/scs_col_sync.sv
module scs_col_sync #(
  parameter int NCOL   = 6,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCOL-1:0] cmp_in,
  output logic [NCOL-1:0] cmp_sync
);
  for (genvar i = 0; i < NCOL; i++) begin : g_col
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], cmp_in[i]};
    end
    assign cmp_sync[i] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/scs_col_store.sv
module scs_col_store
  import scs_pkg::*;
#(
  parameter int NCOL = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_acc,
  input  logic                       run_q,
  input  logic                       cnt_last,
  input  logic                       wr_sel,
  input  logic [NCOL-1:0]            cmp_sync,
  input  code_t                      gray,
  output logic [NCOL-1:0]            keeper_vec,
  output logic [NCOL-1:0]            cap_vec,
  output logic [NCOL-1:0][OUT_W-1:0] rd_words
);
  for (genvar i = 0; i < NCOL; i++) begin : g_col
    logic   keep_q;
    entry_t word0_q, word1_q;
    entry_t wr_ent;

    assign cap_vec[i]    = run_q && !keep_q && (cmp_sync[i] || cnt_last);
    assign wr_ent.ovr    = !cmp_sync[i];
    assign wr_ent.code   = gray;
    assign keeper_vec[i] = keep_q;
    assign rd_words[i]   = wr_sel ? word0_q : word1_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        keep_q  <= 1'b0;
        word0_q <= '0;
        word1_q <= '0;
      end else if (start_acc) begin
        keep_q <= 1'b0;
      end else if (cap_vec[i]) begin
        keep_q <= 1'b1;
        if (wr_sel) word1_q <= wr_ent;
        else        word0_q <= wr_ent;
      end
    end
  end
endmodule

// File: rtl/scs_readout.sv
module scs_readout
  import scs_pkg::*;
#(
  parameter int NCOL   = 6,
  parameter int ADDR_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCOL-1:0][OUT_W-1:0] rd_words,
  input  logic [ADDR_W-1:0]          col_sel,
  output logic [OUT_W-1:0]           col_data
);
  entry_t sel_ent;

  always_comb begin
    sel_ent = '0;
    for (int c = 0; c < NCOL; c++)
      if (col_sel == ADDR_W'(c)) sel_ent = rd_words[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_data <= '0;
    else        col_data <= {sel_ent.ovr, gray2bin(sel_ent.code)};
  end
endmodule

// File: rtl/scs_adc_backend.sv
module scs_adc_backend
  import scs_pkg::*;
#(
  parameter int NCOL   = 6,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic [NCOL-1:0]   cmp_in,
  input  logic [ADDR_W-1:0] col_sel,
  output logic [DAC_W-1:0]  dac_code,
  output logic [CODE_W-1:0] gray_bus,
  output logic [OUT_W-1:0]  col_data
);
  logic                       run_q, start_acc, cnt_last, wr_sel;
  logic [NCOL-1:0]            cmp_sync, keeper_vec, cap_vec;
  logic [NCOL-1:0][OUT_W-1:0] rd_words;

  scs_ramp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start),
    .run_q(run_q), .start_acc(start_acc), .cnt_last(cnt_last),
    .wr_sel(wr_sel), .gray(gray_bus), .dac(dac_code)
  );

  scs_col_sync #(.NCOL(NCOL), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .cmp_sync(cmp_sync)
  );

  scs_col_store #(.NCOL(NCOL)) u_store (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .run_q(run_q),
    .cnt_last(cnt_last), .wr_sel(wr_sel), .cmp_sync(cmp_sync),
    .gray(gray_bus), .keeper_vec(keeper_vec), .cap_vec(cap_vec),
    .rd_words(rd_words)
  );

  scs_readout #(.NCOL(NCOL), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_words(rd_words), .col_sel(col_sel),
    .col_data(col_data)
  );
endmodule

// File: rtl/scs_adc_backend_chk.sv
module scs_adc_backend_chk
  import scs_pkg::*;
#(
  parameter int NCOL   = 6,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_start,
  input logic [ADDR_W-1:0] col_sel,
  input logic [DAC_W-1:0]  dac_code,
  input logic [CODE_W-1:0] gray_bus,
  input logic [OUT_W-1:0]  col_data,
  input logic              run_q,
  input logic              start_acc,
  input logic              cnt_last,
  input logic              wr_sel,
  input logic [NCOL-1:0]   keeper_vec,
  input logic [NCOL-1:0]   cap_vec
);
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> run_q && gray_bus == '0 && dac_code == '0 && keeper_vec == '0
                  && wr_sel != $past(wr_sel));

  assert_gray_one_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !cnt_last |=> $countones(gray_bus ^ $past(gray_bus)) == 1);

  assert_ramp_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !cnt_last |=>
      dac_code == DAC_W'($past(dac_code) + step_of(gray2bin($past(gray_bus)))));

  assert_back_to_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_last |=> !run_q && dac_code == '0 && gray_bus == '0);

  assert_all_columns_filled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_last |=> &keeper_vec);

  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start && run_q && !cnt_last |=> run_q && $stable(wr_sel));

  assert_bad_addr_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col_sel) >= NCOL |=> col_data == '0);

  for (genvar i = 0; i < NCOL; i++) begin : g_keep
    // R6: a capture always leaves the keeper set, so no second capture follows
    assert_keeper_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_vec[i] && !start_acc |=> keeper_vec[i] && !cap_vec[i]);
  end
endmodule

bind scs_adc_backend scs_adc_backend_chk #(.NCOL(NCOL), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .col_sel(col_sel),
  .dac_code(dac_code), .gray_bus(gray_bus), .col_data(col_data),
  .run_q(run_q), .start_acc(start_acc), .cnt_last(cnt_last), .wr_sel(wr_sel),
  .keeper_vec(keeper_vec), .cap_vec(cap_vec)
);

// File: tb/tb_scs_adc_backend.sv
module tb_scs_adc_backend;
  localparam int NCOL = 6;
  localparam int AW   = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            conv_start;
  logic [NCOL-1:0] cmp_in;
  logic [AW-1:0]   col_sel;
  logic [13:0]     dac_code;
  logic [9:0]      gray_bus;
  logic [10:0]     col_data;

  int          total = 0;
  int          bad = 0;
  int          thr [NCOL];
  int unsigned e0 [NCOL], e1 [NCOL], e2 [NCOL], e3 [NCOL];

  always #2 clk = ~clk;

  scs_adc_backend #(.NCOL(NCOL), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cmp_in(cmp_in),
    .col_sel(col_sel), .dac_code(dac_code), .gray_bus(gray_bus),
    .col_data(col_data)
  );

  // comparator model: column trips once the ramp code exceeds its level
  always @(negedge clk)
    for (int i = 0; i < NCOL; i++) cmp_in[i] <= (int'(dac_code) > thr[i]);

  function automatic int ramp_m(int k);
    if (k < 512) return k;
    else if (k < 768) return 2 * k - 512;
    else return 4 * k - 2048;
  endfunction

  // expected word: bit 10 overrange, low bits binary code
  function automatic int unsigned exp_word(int t);
    for (int c = 0; c < 1024; c++)
      if (ramp_m(c) > t) return (c + 2 <= 1023) ? c + 2 : 1024 + 1023;
    return 1024 + 1023;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic read_all(input int unsigned pexp [NCOL]);
    for (int a = 0; a < 8; a++) begin
      int unsigned ev;
      string req;
      ev = (a < NCOL) ? pexp[a] : 0;
      if (a >= NCOL) req = "R10";
      else if (ev >= 1024) req = "R7 R8 R9";
      else req = "R5 R6 R8 R9";
      col_sel = AW'(a);
      @(negedge clk);
      chk(int'(col_data) == int'(ev), req, int'(col_data), int'(ev));
    end
  endtask

  task automatic run_conv(input bit poke, input int unsigned pexp [NCOL]);
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    fork
      begin
        for (int k = 0; k < 1024; k++) begin
          chk(int'(dac_code) == ramp_m(k), "R3 R11 ramp", int'(dac_code), ramp_m(k));
          chk(int'(gray_bus) == (k ^ (k >> 1)), "R2 R11 gray", int'(gray_bus), k ^ (k >> 1));
          @(negedge clk);
        end
      end
      begin
        repeat (50) @(negedge clk);
        read_all(pexp);
      end
      begin
        if (poke) begin
          repeat (300) @(negedge clk);
          conv_start = 1'b1;   // R11: must be ignored
          @(negedge clk);
          conv_start = 1'b0;
        end
      end
    join
    chk(dac_code == 14'd0, "R4 dac idle", int'(dac_code), 0);
    chk(gray_bus == 10'd0, "R4 gray idle", int'(gray_bus), 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; conv_start = 1'b0; col_sel = '0;
    for (int i = 0; i < NCOL; i++) begin thr[i] = 0; e0[i] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dac_code == 14'd0, "R1 dac", int'(dac_code), 0);
    chk(gray_bus == 10'd0, "R1 gray", int'(gray_bus), 0);
    chk(col_data == 11'd0, "R1 data", int'(col_data), 0);

    // directed levels: lowest, segment edge, trip at 1023, late trip, never, top segment
    thr[0] = 0; thr[1] = 511; thr[2] = 2035; thr[3] = 2039; thr[4] = 5000; thr[5] = 1200;
    for (int i = 0; i < NCOL; i++) e1[i] = exp_word(thr[i]);
    run_conv(1'b1, e0);
    read_all(e0);              // R8: before the second start, zeros

    for (int i = 0; i < NCOL; i++) begin thr[i] = int'($urandom_range(0, 2100)); e2[i] = exp_word(thr[i]); end
    run_conv(1'b0, e1);
    for (int i = 0; i < NCOL; i++) begin thr[i] = int'($urandom_range(0, 2100)); e3[i] = exp_word(thr[i]); end
    run_conv(1'b0, e2);
    for (int i = 0; i < NCOL; i++) thr[i] = int'($urandom_range(0, 2100));
    run_conv(1'b1, e3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule